// File: doc/BRIEF.md
# System Management Mode Command Sequencer

This block takes writes to a 5-bit, write-only command register and turns each accepted write into an ordered series of system-management actions. It can drop the internal SMI-pending flag, switch the protected memory window on or off, start or end the NMI/SMI blocking that goes with management mode, and raise one-cycle strobes that ask the bus logic for an SMI or RSM special cycle. The bus cycles themselves are produced elsewhere.

One write may carry several command bits. Their order of execution is fixed and does not follow their bit positions. The block issues one action per clock and raises `busy` until the last action has run. Before a write starts anything, the block screens it. A write made while the hardware lock is set gives a general-protection fault pulse. A write with an illegal bit combination, a write that would nest or mismatch enter and exit, or a write made while busy gives an error pulse. In every one of these cases no action takes place.

Top module: `smm_cmd_seq`

## Requirements
- R1: After reset, `smram_map`, `nmi_block`, `smi_block`, `busy`, all strobes, `gp_fault` and `cmd_error` are 0.
- R2: Enter (bit 1) sets `smram_map`, `nmi_block` and `smi_block`, and saves the level `nmi_in` had in the cycle the enter ran.
- R3: Exit (bit 3) clears `smram_map` and `smi_block`, and returns `nmi_block` to the level saved by the matching enter.
- R4: Dismiss (bit 0) pulses `clr_smi_pend`, SMI-cycle (bit 2) pulses `smi_cyc_req` and RSM-cycle (bit 4) pulses `rsm_cyc_req`, each high for exactly one cycle.
- R5: The actions of one write run one per clock in the order enter, SMI-cycle, dismiss, RSM-cycle, exit. The first action takes effect one cycle after the write edge, and `busy` stays high for as many cycles as there are actions.
- R6: Single bits are legal. The only legal multi-bit values are 0x06, 0x03, 0x07 and 0x18. Any other value pulses `cmd_error` for one cycle and starts no action.
- R7: A write while `hw_lock` is 1 pulses `gp_fault` for one cycle, does not pulse `cmd_error`, and starts no action.
- R8: Enter while `smram_map` is 1, or exit while it is 0, pulses `cmd_error` and starts no action.
- R9: A write while `busy` is 1 pulses `cmd_error`, and the running sequence finishes unchanged.
- R10: `rd_data` reads 0 at all times.
- R11: A write of 0x00 with the lock clear starts no action and raises neither `cmd_error` nor `gp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 5 | Command bits |
| hw_lock | input | 1 | Hardware lock on management controls |
| nmi_in | input | 1 | Present NMI-blocked level |
| rd_data | output | 5 | Read value, always zero |
| busy | output | 1 | A sequence is running |
| smram_map | output | 1 | Protected memory window mapped |
| nmi_block | output | 1 | NMI blocked |
| smi_block | output | 1 | SMI blocked |
| clr_smi_pend | output | 1 | One-cycle strobe that clears SMI pending |
| smi_cyc_req | output | 1 | One-cycle SMI special-cycle request |
| rsm_cyc_req | output | 1 | One-cycle RSM special-cycle request |
| gp_fault | output | 1 | One-cycle general-protection fault |
| cmd_error | output | 1 | One-cycle rejected-command flag |

## Verification
The bench runs the three-action write 0x07 cycle by cycle. A design that followed bit order would show the dismiss strobe before the window maps. The bench saves NMI as blocked at one enter and as unblocked at another, and checks each exit. A design that always cleared NMI blocking would fail the first case. It sends exits outside management mode, repeats an enter, writes illegal pairs, writes while locked and writes in mid-sequence. A design with weak screening would change the mapping state, or would disturb the running sequence, in those cases.

// File: rtl/smm_cmd_pkg.sv
package smm_cmd_pkg;
  localparam int CMD_W = 5;
  localparam int B_DISMISS = 0;
  localparam int B_ENTER   = 1;
  localparam int B_SMICYC  = 2;
  localparam int B_EXIT    = 3;
  localparam int B_RSMCYC  = 4;

  typedef logic [CMD_W-1:0] cmd_t;

  // execution priority, first entry runs first
  localparam int ORDER [CMD_W] = '{B_ENTER, B_SMICYC, B_DISMISS, B_RSMCYC, B_EXIT};

  typedef enum logic [1:0] {
    WR_NONE, WR_ACCEPT, WR_ERROR, WR_FAULT
  } wr_verdict_e;

  function automatic logic cmd_legal(input cmd_t c);
    cmd_t ent_smi, dis_ent, dis_ent_smi, ext_rsm;
    ent_smi     = '0; ent_smi[B_ENTER] = 1'b1; ent_smi[B_SMICYC] = 1'b1;
    dis_ent     = '0; dis_ent[B_ENTER] = 1'b1; dis_ent[B_DISMISS] = 1'b1;
    dis_ent_smi = ent_smi | dis_ent;
    ext_rsm     = '0; ext_rsm[B_EXIT] = 1'b1; ext_rsm[B_RSMCYC] = 1'b1;
    return ($countones(c) <= 1) || (c == ent_smi) || (c == dis_ent) ||
           (c == dis_ent_smi) || (c == ext_rsm);
  endfunction
endpackage

// File: rtl/smm_cmd_screen.sv
module smm_cmd_screen
  import smm_cmd_pkg::*;
(
  input  logic        wr_en,
  input  cmd_t        wr_data,
  input  logic        hw_lock,
  input  logic        busy,
  input  logic        in_smm,
  output wr_verdict_e verdict
);
  logic legal;

  always_comb begin
    legal = cmd_legal(wr_data);
    if (!wr_en)                              verdict = WR_NONE;
    else if (hw_lock)                        verdict = WR_FAULT;
    else if (busy)                           verdict = WR_ERROR;
    else if (!legal)                         verdict = WR_ERROR;
    else if (wr_data[B_ENTER] && in_smm)     verdict = WR_ERROR;
    else if (wr_data[B_EXIT] && !in_smm)     verdict = WR_ERROR;
    else                                     verdict = WR_ACCEPT;
  end
endmodule

// File: rtl/smm_action_seq.sv
module smm_action_seq
  import smm_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cmd_t load_cmd,
  output cmd_t act,
  output logic busy
);
  cmd_t mask_q, mask_d, pick;
  logic found;
  logic mask_en;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < CMD_W; i++) begin
      if (!found && mask_q[ORDER[i]]) begin
        pick[ORDER[i]] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    mask_en = load || (mask_q != '0);
    mask_d  = load ? load_cmd : (mask_q & ~pick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign act  = pick;
  assign busy = (mask_q != '0);

  // R5
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

  // R9
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/smm_mode_state.sv
module smm_mode_state
  import smm_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t act,
  input  logic nmi_in,
  output logic smram_map,
  output logic nmi_block,
  output logic smi_block,
  output logic clr_smi_pend,
  output logic smi_cyc_req,
  output logic rsm_cyc_req
);
  logic map_q, map_d, nmi_q, nmi_d, smi_q, smi_d, saved_q, saved_d;
  logic clr_q, scyc_q, rcyc_q;
  logic mode_en, save_en;

  always_comb begin
    mode_en = act[B_ENTER] || act[B_EXIT];
    save_en = act[B_ENTER];
    map_d   = act[B_ENTER];
    smi_d   = act[B_ENTER];
    nmi_d   = act[B_ENTER] ? 1'b1 : saved_q;
    saved_d = nmi_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= 1'b0;
      nmi_q <= 1'b0;
      smi_q <= 1'b0;
    end else if (mode_en) begin
      map_q <= map_d;
      nmi_q <= nmi_d;
      smi_q <= smi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_q <= 1'b0;
    else if (save_en) saved_q <= saved_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      scyc_q <= 1'b0;
      rcyc_q <= 1'b0;
    end else begin
      clr_q  <= act[B_DISMISS];
      scyc_q <= act[B_SMICYC];
      rcyc_q <= act[B_RSMCYC];
    end
  end

  assign smram_map    = map_q;
  assign nmi_block    = nmi_q;
  assign smi_block    = smi_q;
  assign clr_smi_pend = clr_q;
  assign smi_cyc_req  = scyc_q;
  assign rsm_cyc_req  = rcyc_q;

  // R2
  enter_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act[B_ENTER] |=> (smram_map && nmi_block && smi_block && saved_q == $past(nmi_in)));

  // R3
  exit_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act[B_EXIT] |=> (!smram_map && !smi_block && nmi_block == $past(saved_q)));

  // R3
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[B_ENTER] || act[B_EXIT]) |=> $stable(smram_map));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_smi_pend, smi_cyc_req, rsm_cyc_req}));
endmodule

// File: rtl/smm_cmd_seq.sv
module smm_cmd_seq
  import smm_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  input  logic       hw_lock,
  input  logic       nmi_in,
  output logic [4:0] rd_data,
  output logic       busy,
  output logic       smram_map,
  output logic       nmi_block,
  output logic       smi_block,
  output logic       clr_smi_pend,
  output logic       smi_cyc_req,
  output logic       rsm_cyc_req,
  output logic       gp_fault,
  output logic       cmd_error
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;
  wr_verdict_e            verdict;
  cmd_t                   act;
  logic                   err_d, err_q, gp_d, gp_q, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  smm_cmd_screen u_screen (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hw_lock (hw_lock),
    .busy    (busy),
    .in_smm  (smram_map),
    .verdict (verdict)
  );

  always_comb begin
    load  = (verdict == WR_ACCEPT);
    err_d = (verdict == WR_ERROR);
    gp_d  = (verdict == WR_FAULT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      gp_q  <= 1'b0;
    end else begin
      err_q <= err_d;
      gp_q  <= gp_d;
    end
  end

  smm_action_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (load),
    .load_cmd (wr_data),
    .act      (act),
    .busy     (busy)
  );

  smm_mode_state u_state (
    .clk          (clk),
    .rst_n        (rst_ni),
    .act          (act),
    .nmi_in       (nmi_in),
    .smram_map    (smram_map),
    .nmi_block    (nmi_block),
    .smi_block    (smi_block),
    .clr_smi_pend (clr_smi_pend),
    .smi_cyc_req  (smi_cyc_req),
    .rsm_cyc_req  (rsm_cyc_req)
  );

  assign rd_data   = '0;
  assign gp_fault  = gp_q;
  assign cmd_error = err_q;

  // R7
  lock_fault_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && hw_lock) |=> (gp_fault && !cmd_error));

  // R7
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && hw_lock && !busy) |=> !busy);

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !hw_lock && busy) |=> cmd_error);

  // R8
  nest_enter_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !hw_lock && !busy && wr_data[B_ENTER] && smram_map) |=> (cmd_error && !busy));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(gp_fault && cmd_error));
endmodule

// File: tb/smm_cmd_seq_bench.sv
module smm_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, hw_lock, nmi_in;
  logic [4:0] wr_data;
  logic [4:0] rd_data;
  logic       busy, smram_map, nmi_block, smi_block;
  logic       clr_smi_pend, smi_cyc_req, rsm_cyc_req, gp_fault, cmd_error;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  smm_cmd_seq u_smm_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_lock(hw_lock), .nmi_in(nmi_in), .rd_data(rd_data), .busy(busy),
    .smram_map(smram_map), .nmi_block(nmi_block), .smi_block(smi_block),
    .clr_smi_pend(clr_smi_pend), .smi_cyc_req(smi_cyc_req),
    .rsm_cyc_req(rsm_cyc_req), .gp_fault(gp_fault), .cmd_error(cmd_error)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // lock, nmi, data, err, gp, nacts, map, nmi_blk
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b0},  // R11 zero write
    {1'b0, 1'b0, 5'h08, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'b0},  // R8 exit outside
    {1'b0, 1'b0, 5'h0A, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'b0},  // R6 enter+exit
    {1'b0, 1'b1, 5'h02, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 3'b0},  // R2 enter, nmi was 1
    {1'b0, 1'b0, 5'h02, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 3'b0},  // R8 nested enter
    {1'b0, 1'b0, 5'h01, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 3'b0},  // R4 dismiss
    {1'b1, 1'b0, 5'h18, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 3'b0},  // R7 locked
    {1'b0, 1'b0, 5'h18, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 3'b0},  // R3 restore 1
    {1'b0, 1'b0, 5'h07, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 3'b0},  // R5 enter, nmi was 0
    {1'b0, 1'b0, 5'h08, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 3'b0},  // R3 restore 0
    {1'b0, 1'b0, 5'h14, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 3'b0},  // R6 smi+rsm
    {1'b0, 1'b0, 5'h04, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 3'b0}   // R4 smi cycle
  };

  task automatic do_write(input logic lk, input logic [4:0] d);
    @(negedge clk);
    hw_lock = lk; wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; hw_lock = 1'b0; wr_data = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; hw_lock = 1'b0; nmi_in = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "map", smram_map, 0);
    check("R1", "blocks", {nmi_block, smi_block}, 0);
    check("R1", "pulses", {clr_smi_pend, smi_cyc_req, rsm_cyc_req, gp_fault, cmd_error}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      int cnt;
      e = VEC[v];
      nmi_in = e[14];
      @(negedge clk);
      hw_lock = e[15]; wr_en = 1'b1; wr_data = e[13:9];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; hw_lock = 1'b0;
      check("R6", $sformatf("vec%0d error", v), cmd_error, e[8]);
      check("R7", $sformatf("vec%0d fault", v), gp_fault, e[7]);
      cnt = 0;
      while (busy && cnt < 10) begin
        @(posedge clk); @(negedge clk); cnt++;
      end
      check("R5", $sformatf("vec%0d actions", v), cnt, e[6:5]);
      check("R2", $sformatf("vec%0d map", v), smram_map, e[4]);
      check("R3", $sformatf("vec%0d nmi_block", v), nmi_block, e[3]);
      check("R3", $sformatf("vec%0d smi_block", v), smi_block, e[4]);
      check("R10", $sformatf("vec%0d rd_data", v), rd_data, 0);
    end

    // R5 order: write 0x07 from outside, then a busy write (R9)
    nmi_in = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_data = 5'h07;
    @(posedge clk); @(negedge clk);
    wr_data = 5'h02;                          // R9 write while busy
    check("R5", "busy after write", busy, 1);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R5", "enter first", {smram_map, smi_cyc_req, clr_smi_pend}, 3'b100);
    check("R9", "busy write error", cmd_error, 1);
    @(posedge clk); @(negedge clk);
    check("R5", "smi cycle second", {smi_cyc_req, clr_smi_pend}, 2'b10);
    @(posedge clk); @(negedge clk);
    check("R5", "dismiss third", {smi_cyc_req, clr_smi_pend, busy}, 3'b010);
    @(posedge clk); @(negedge clk);
    check("R4", "dismiss one cycle", clr_smi_pend, 0);
    check("R9", "sequence intact", {smram_map, busy}, 2'b10);

    // R5 exit + rsm: rsm before exit
    do_write(1'b0, 5'h18);
    @(posedge clk); @(negedge clk);
    check("R5", "rsm before exit", {rsm_cyc_req, smram_map}, 2'b11);
    @(posedge clk); @(negedge clk);
    check("R5", "exit last", {rsm_cyc_req, smram_map, busy}, 3'b000);
    check("R4", "rsm one cycle", rsm_cyc_req, 0);
    check("R10", "rd_data end", rd_data, 0);

    summary();
  end
endmodule